// File: doc/BRIEF.md
# Serial Character Receiver with Overrun Retention and Half-Bit Echo

This block recovers characters from an asynchronous serial line. It watches the incoming line `rxd` on a 16x oversampling tick. Each frame is a low start bit, `DATA_BITS` data bits sent least significant bit first, an optional parity bit, and a high stop bit. A character that has been fully received is moved into a holding register that a processor reads. The block then requests service on an active-low interrupt line. A status vector reports whether the register is full, whether a parity or framing error occurred, and whether an overrun occurred.

When the processor falls behind, the holding register keeps the last character it accepted. Every character that arrives after it is dropped until the processor reads the register. An echo mode sends the incoming bit stream back out on `txd`, half a bit period later. This lets a remote terminal see its own keystrokes. When echo mode is off, `txd` rests high.

Top module: `uart_echo_rx`

## Requirements
- R1: A frame is one low start bit, then `DATA_BITS` (default 8) data bits, least significant first, then one even-parity bit when `PARITY_EN`=1 (the parity bit equals the XOR of the data bits), then one high stop bit. Each bit lasts 16 ticks. After a frame is accepted, `rxData` shows the data bits.
- R2: A character that completes while the holding register is empty is transferred into it. Status bit 0 (full) is then set and `irqN` goes low.
- R3: A character that completes while the register is full and no read is pending is not transferred. `rxData` keeps the previous value.
- R4: In the case of R3, status bit 3 (overrun) is set.
- R5: Every further character that arrives while the register is still unread is also lost. `rxData` and the overrun flag stay unchanged.
- R6: A one-cycle `dataRd` pulse clears status bit 0 and status bit 3. It also returns `irqN` high.
- R7: If `dataRd` falls in the same cycle as a character completing, the new character is accepted. Full stays set and overrun stays clear.
- R8: A low level on `rxd` that is high again at the half-bit check (8 ticks after the fall) is discarded as a false start. No character is produced.
- R9: Status bit 1 reports a parity mismatch and status bit 2 reports a low stop bit. Both are updated only when a character is transferred, so a lost character leaves them unchanged.
- R10: When `echoEn` is 1, `txd` repeats the synchronized `rxd` delayed by 8 ticks. That is `rxd` from 10 clocks earlier when a tick occurs every clock. When `echoEn` is 0, `txd` is 1.
- R11: After reset, `status` is 0, `rxData` is 0, `irqN` is 1 and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Oversampling tick, 16 per bit period |
| rxd | input | 1 | Asynchronous serial input |
| echoEn | input | 1 | Enables the echo path onto `txd` |
| dataRd | input | 1 | One-cycle read strobe for the holding register |
| rxData | output | DATA_BITS | Holding register contents |
| status | output | 4 | {overrun, framing error, parity error, full} |
| irqN | output | 1 | Active-low receive-full interrupt request |
| txd | output | 1 | Echo output, high when echo is off |

## Verification
The processor read and the completion of a new character can fall in the same clock cycle. The read then competes with the overrun decision over the full flag. The bench leaves one character unread and sends a second. It raises `dataRd` for exactly the clock edge on which the stop bit is sampled. That edge is 170 clocks after the clock that first sees the start bit. The bench then expects the second character in `rxData`, with overrun clear and full set. Echo is checked throughout a frame against a 10-clock-delayed record of the driven line.

// File: rtl/uart_echo_rx_pkg.sv
package uart_echo_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;    // capture one data bit
    logic parSample;  // capture the parity bit
    logic stopSample; // capture stop bit, character complete
  } rxStrobe_t;
endpackage

// File: rtl/uart_echo_rx_ctrl.sv
module uart_echo_rx_ctrl
  import uart_echo_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxSync,
  output rxStrobe_t strobe
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int IDX_W  = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rxState_t state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic atMid;

  assign atMid = sampleTick && (tickCnt == FULL_CNT);

  always_comb begin
    strobe = '0;
    strobe.shiftEn    = (state == RX_DATA)   && atMid;
    strobe.parSample  = (state == RX_PARITY) && atMid;
    strobe.stopSample = (state == RX_STOP)   && atMid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          if (!rxSync) state <= RX_START;
        end
        RX_START: begin
          if (tickCnt == HALF_CNT) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxSync ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_CNT) begin
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == LAST_IDX) state <= PARITY_EN ? RX_PARITY : RX_STOP;
          end
        end
        RX_PARITY: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_CNT) state <= RX_STOP;
        end
        RX_STOP: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_CNT) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R8: a start level gone at the half-bit check returns to idle
  a_r8_false_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && sampleTick && tickCnt == HALF_CNT && rxSync) |=> state == RX_IDLE);

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftEn, strobe.parSample, strobe.stopSample}));
endmodule

// File: rtl/uart_echo_rx_dp.sv
module uart_echo_rx_dp
  import uart_echo_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVS        = 16,
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxd,
  input  logic                 echoEn,
  input  logic                 dataRd,
  input  rxStrobe_t            strobe,
  output logic                 rxSync,
  output logic [DATA_BITS-1:0] dataReg,
  output logic                 fullFlag,
  output logic                 parErr,
  output logic                 frmErr,
  output logic                 ovrFlag,
  output logic                 txd
);
  localparam int ECHO_TAPS = OVS / 2;

  logic                 syncFf;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 accept;
  logic                 parBad;
  logic                 echoOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncFf <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      syncFf <= rxd;
      rxSync <= syncFf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.shiftEn)   shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
      if (strobe.parSample) parBit   <= rxSync;
    end
  end

  assign parBad = PARITY_EN ? (parBit != ((^shiftReg) ^ PARITY_ODD)) : 1'b0;
  assign accept = strobe.stopSample && (!fullFlag || dataRd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      fullFlag <= 1'b0;
      parErr   <= 1'b0;
      frmErr   <= 1'b0;
      ovrFlag  <= 1'b0;
    end else if (accept) begin
      dataReg  <= shiftReg;
      fullFlag <= 1'b1;
      parErr   <= parBad;
      frmErr   <= !rxSync;
      ovrFlag  <= 1'b0;
    end else if (dataRd) begin
      fullFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end else if (strobe.stopSample) begin
      ovrFlag  <= 1'b1;
    end
  end

  generate
    if (ECHO_TAPS > 1) begin : g_echoLine
      logic [ECHO_TAPS-1:0] echoLine;
      always_ff @(posedge clk) begin
        if (!rstN) echoLine <= '1;
        else if (sampleTick) echoLine <= {echoLine[ECHO_TAPS-2:0], rxSync};
      end
      assign echoOut = echoLine[ECHO_TAPS-1];
    end else begin : g_echoSingle
      logic echoBit;
      always_ff @(posedge clk) begin
        if (!rstN) echoBit <= 1'b1;
        else if (sampleTick) echoBit <= rxSync;
      end
      assign echoOut = echoBit;
    end
  endgenerate

  assign txd = echoEn ? echoOut : 1'b1;

  a_r2_fill: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopSample && !fullFlag) |=> fullFlag);
  a_r3_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && !dataRd) |=> $stable(dataReg));
  a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopSample && fullFlag && !dataRd) |=> ovrFlag);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !strobe.stopSample) |=> (!fullFlag && !ovrFlag));
  a_r7_read_and_fill: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && strobe.stopSample) |=> (fullFlag && !ovrFlag));
  a_r9_err_stable: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> ($stable(parErr) && $stable(frmErr)));
endmodule

// File: rtl/uart_echo_rx.sv
module uart_echo_rx
  import uart_echo_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVS        = 16,
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxd,
  input  logic                 echoEn,
  input  logic                 dataRd,
  output logic [DATA_BITS-1:0] rxData,
  output logic [3:0]           status,
  output logic                 irqN,
  output logic                 txd
);
  rxStrobe_t strobe;
  logic rxSync, fullFlag, parErr, frmErr, ovrFlag;

  uart_echo_rx_ctrl #(
    .DATA_BITS(DATA_BITS), .OVS(OVS), .PARITY_EN(PARITY_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxSync(rxSync), .strobe(strobe)
  );

  uart_echo_rx_dp #(
    .DATA_BITS(DATA_BITS), .OVS(OVS), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxd(rxd), .echoEn(echoEn),
    .dataRd(dataRd), .strobe(strobe), .rxSync(rxSync), .dataReg(rxData),
    .fullFlag(fullFlag), .parErr(parErr), .frmErr(frmErr), .ovrFlag(ovrFlag), .txd(txd)
  );

  assign status = {ovrFlag, frmErr, parErr, fullFlag};
  assign irqN   = ~fullFlag;

  a_r10_echo_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!echoEn && !$past(echoEn)) |-> txd);
endmodule

// File: tb/tb_uart_echo_rx.sv
module tb_uart_echo_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b1;
  logic rxd = 1'b1;
  logic echoEn = 1'b0;
  logic dataRd = 1'b0;
  logic [7:0] rxData;
  logic [3:0] status;
  logic irqN;
  logic txd;

  int checks = 0;
  int errors = 0;
  logic rxLog [0:255];

  // vector: data, flip parity bit, low stop bit, expected status after accept
  typedef struct packed {
    logic [7:0] data;
    logic       badPar;
    logic       badStop;
    logic [3:0] expStat;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1'b0, 1'b0, 4'b0001},
    '{8'h00, 1'b0, 1'b0, 4'b0001},
    '{8'hFF, 1'b0, 1'b0, 4'b0001},
    '{8'h3C, 1'b1, 1'b0, 4'b0011},
    '{8'h81, 1'b0, 1'b1, 4'b0101},
    '{8'h7E, 1'b1, 1'b1, 4'b0111}
  };

  uart_echo_rx dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxd(rxd), .echoEn(echoEn),
    .dataRd(dataRd), .rxData(rxData), .status(status), .irqN(irqN), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one frame, one negedge per step. rdStep >= 0 pulses dataRd so it is
  // high at the posedge after negedge rdStep. echoChk compares txd with rxd 10 steps ago.
  task automatic sendFrame(input logic [7:0] d, input logic badPar, input logic badStop,
                           input int rdStep, input logic echoChk);
    logic [10:0] bits;
    bits = {~badStop, (^d) ^ badPar, d, 1'b0};
    for (int i = 0; i < 256; i++) rxLog[i] = 1'b1;
    for (int n = 0; n < 11 * 16 + 8; n++) begin
      @(negedge clk);
      if (echoChk && n >= 10) check("R10 echo", {31'd0, txd}, {31'd0, rxLog[n-10]});
      rxd = (n < 176) ? bits[n/16] : 1'b1;
      rxLog[n] = rxd;
      dataRd = (rdStep >= 0 && n == rdStep);
    end
    dataRd = 1'b0;
  endtask

  task automatic readReg();
    @(negedge clk); dataRd = 1'b1;
    @(negedge clk); dataRd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check("R11 status", {28'd0, status}, 32'd0);
    check("R11 rxData", {24'd0, rxData}, 32'd0);
    check("R11 irqN", {31'd0, irqN}, 32'd1);
    check("R11 txd", {31'd0, txd}, 32'd1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R9 R6: vector table
    for (int v = 0; v < NVEC; v++) begin
      sendFrame(VECS[v].data, VECS[v].badPar, VECS[v].badStop, -1, 1'b0);
      check("R1 data", {24'd0, rxData}, {24'd0, VECS[v].data});
      check("R2/R9 status", {28'd0, status}, {28'd0, VECS[v].expStat});
      check("R2 irqN low", {31'd0, irqN}, 32'd0);
      readReg();
      check("R6 full cleared", {31'd0, status[0]}, 32'd0);
      check("R6 irqN high", {31'd0, irqN}, 32'd1);
    end

    // R3 R4 R5 R9: overrun retention
    sendFrame(8'h11, 1'b0, 1'b0, -1, 1'b0);
    sendFrame(8'h22, 1'b0, 1'b0, -1, 1'b0);
    check("R3 data held", {24'd0, rxData}, 32'h11);
    check("R4 overrun set", {28'd0, status}, 32'b1001);
    sendFrame(8'h33, 1'b1, 1'b1, -1, 1'b0);
    check("R5 still held", {24'd0, rxData}, 32'h11);
    check("R9 errors untouched by lost char", {28'd0, status}, 32'b1001);
    readReg();
    check("R6 overrun cleared", {28'd0, status}, 32'b0000);
    check("R6 irqN after read", {31'd0, irqN}, 32'd1);

    // R7: read coincides with stop-bit sample (posedge after negedge step 170)
    sendFrame(8'h44, 1'b0, 1'b0, -1, 1'b0);
    sendFrame(8'h55, 1'b0, 1'b0, 170, 1'b0);
    check("R7 new char accepted", {24'd0, rxData}, 32'h55);
    check("R7 full set no overrun", {28'd0, status}, 32'b0001);
    readReg();

    // R8: false start glitch
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    check("R8 no char after glitch", {28'd0, status}, 32'd0);
    sendFrame(8'h69, 1'b0, 1'b0, -1, 1'b0);
    check("R8 next frame ok", {24'd0, rxData}, 32'h69);
    readReg();

    // R10: echo on during a frame, then off
    echoEn = 1'b1;
    repeat (20) @(negedge clk);
    sendFrame(8'hC3, 1'b0, 1'b0, -1, 1'b1);
    echoEn = 1'b0;
    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk);
    check("R10 txd idle when off", {31'd0, txd}, 32'd1);
    rxd = 1'b1;
    repeat (200) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule